// File: doc/BRIEF.md
# Mains Return and Failure Qualifier

This block watches a stream of signed AC-mains voltage samples and decides two things: when mains has come back cleanly enough to be trusted, and when a trusted mains has failed. Return is qualified in four stages. First, the line must show high voltage persistently. Next, a clean rising zero crossing must be found, with noise rejected. Then one full cycle is learned as a reference, averaged over four consecutive cycles. Finally, the live samples must stay close to that reference for a sustained run. Once mains is declared present, every sample is compared against the reference at its position within the cycle. A run of consecutive out-of-band samples declares a failure.

The controller is a five-state machine:

- HOLD: waits for persistent high voltage.
  - HOLD to SEEK, once the persistence run is met.
- SEEK: waits for a valid rising crossing.
  - SEEK to LEARN, on a valid crossing.
- LEARN: accumulates four cycles into the reference store.
  - LEARN to QUAL, on the fifth crossing.
  - LEARN to HOLD, when a cycle overruns the store.
- QUAL: counts consecutive in-band samples.
  - QUAL to PRESENT, after the required in-band run.
- PRESENT: asserts mains-ok and counts consecutive out-of-band samples.
  - PRESENT to HOLD, after the failure run.

While tracking, the block reports the position of each sample within the learned cycle, together with its quadrant.

Top module: `mains_qual`

## Requirements
- R1: After reset, mains_ok and mains_fail are 0 and smp_idx is 0.
- R2: A sample counts as high when its magnitude is at least HI_LVL. The ZC search starts only after HOLD_N consecutive samples in which the run of non-high samples never exceeds GAP_MAX. A non-high run counts from the last high sample, and from reset no high sample has been seen.
- R3: A rising zero crossing is valid only when the previous sample is negative, the current sample is greater than zero, and the current sample minus the previous one exceeds ZC_RISE. An invalid crossing does not start learning, so smp_idx stays unchanged.
- R4: The reference is learned over the four cycles that follow a valid crossing. A cycle ends at the next valid crossing. Each entry is the sum of four samples shifted right arithmetically by two, and tracking starts after the fifth crossing.
- R5: While qualifying, a sample is in band when the absolute difference between it and the reference at its index is at most BAND. mains_ok rises right after the QUAL_N-th consecutive in-band sample. Any out-of-band sample restarts this count from zero.
- R6: While mains is present, FAIL_N consecutive out-of-band samples set mains_fail and clear mains_ok on the same edge. Any in-band sample resets the consecutive count.
- R7: After a failure, the block restarts at the persistence stage. mains_fail stays 1 until mains_ok next rises, and then drops on that same edge.
- R8: smp_idx is 0 for the sample of each valid crossing and increments by one for every sample. While tracking, it wraps to 0 when it reaches the cycle length captured between the last two crossings of learning.
- R9: smp_quad reports the quadrant of smp_idx within the captured length L: 0 below L>>2, 1 below L>>1, 2 below (3L)>>2, and 3 otherwise.
- R10: mains_ok and mains_fail are never both 1, and neither output nor smp_idx changes except on the edge that accepts a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Strobe marking smp_in as a new sample |
| smp_in | input | W | Signed mains voltage sample |
| smp_idx | output | $clog2(MAX_LEN) | Position of the latest sample within the learned cycle |
| smp_quad | output | 2 | Quadrant of smp_idx within the captured cycle length |
| mains_ok | output | 1 | Mains has been qualified as present |
| mains_fail | output | 1 | Mains failure declared, held until the next qualification |

## Verification
The hardest situation to reach is a requalification after a failure, because it needs the whole chain to run twice. The first pass must learn, qualify and reach the present state. An out-of-band burst must then push the block back through persistence, crossing search and a second learning pass, and a glitch must restart the second qualification. The stimulus is one long synthetic sine whose sample phase is known exactly. Offsets are added at chosen phases, so every crossing, stage boundary and expected edge of mains_ok and mains_fail falls out of simple arithmetic on the period and the count parameters. Separate runs cover three further cases: a noisy crossing inserted during the search, a low-amplitude lead-in that must not count toward persistence, and a second period that exercises index wrap.

// File: rtl/mq_pkg.sv
package mq_pkg;

    typedef enum logic [2:0] {
        MQ_HOLD,
        MQ_SEEK,
        MQ_LEARN,
        MQ_QUAL,
        MQ_PRESENT
    } mq_state_e;

endpackage

// File: rtl/mq_zc_det.sv
module mq_zc_det #(
    parameter int W       = 12,
    parameter int ZC_RISE = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic signed [W-1:0] smp_in,
    output logic                zc
);

    localparam logic signed [W:0] RISE_MIN = (W+1)'(ZC_RISE);

    logic signed [W-1:0] prev_q;
    logic signed [W:0]   rise;
    logic                cur_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (smp_vld) begin
            prev_q <= smp_in;
        end
    end

    assign rise    = $signed({smp_in[W-1], smp_in}) - $signed({prev_q[W-1], prev_q});
    assign cur_pos = !smp_in[W-1] && (smp_in != '0);
    assign zc      = smp_vld && prev_q[W-1] && cur_pos && (rise > RISE_MIN);

endmodule

// File: rtl/mq_ref_mem.sv
module mq_ref_mem #(
    parameter int W     = 12,
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                wr_add,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic signed [W-1:0] wr_val,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic signed [W-1:0] rd_ref
);

    localparam int ACC_W = W + 2;

    logic signed [ACC_W-1:0] acc_q [DEPTH];
    logic signed [ACC_W-1:0] wr_ext;
    logic signed [ACC_W-1:0] rd_sum;

    assign wr_ext = ACC_W'(wr_val);

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                acc_q[i] <= wr_add ? acc_q[i] + wr_ext : wr_ext;
            end
        end
    end

    assign rd_sum = acc_q[rd_idx];
    assign rd_ref = W'(rd_sum >>> 2);

endmodule

// File: rtl/mq_band.sv
module mq_band #(
    parameter int W     = 12,
    parameter int BAND  = 20,
    parameter int IDX_W = 5,
    parameter int LEN_W = 6
) (
    input  logic signed [W-1:0] smp_in,
    input  logic signed [W-1:0] ref_val,
    input  logic [IDX_W-1:0]    idx,
    input  logic [LEN_W-1:0]    len,
    output logic                in_band,
    output logic [1:0]          quad
);

    localparam logic [W:0] BAND_LIM = (W+1)'(BAND);
    localparam int         QW       = LEN_W + 2;

    logic signed [W:0] err;
    logic [W:0]        err_mag;
    logic [QW-1:0]     len_x, idx_x, q1, q2, q3;

    assign err     = $signed({smp_in[W-1], smp_in}) - $signed({ref_val[W-1], ref_val});
    assign err_mag = err[W] ? -err : err;
    assign in_band = err_mag <= BAND_LIM;

    assign len_x = QW'(len);
    assign idx_x = QW'(idx);
    assign q1    = len_x >> 2;
    assign q2    = len_x >> 1;
    assign q3    = (len_x + (len_x << 1)) >> 2;

    always_comb begin
        if (idx_x < q1)      quad = 2'd0;
        else if (idx_x < q2) quad = 2'd1;
        else if (idx_x < q3) quad = 2'd2;
        else                 quad = 2'd3;
    end

endmodule

// File: rtl/mains_qual.sv
module mains_qual
    import mq_pkg::*;
#(
    parameter int W       = 12,
    parameter int MAX_LEN = 32,
    parameter int HOLD_N  = 25,
    parameter int GAP_MAX = 12,
    parameter int HI_LVL  = 300,
    parameter int ZC_RISE = 40,
    parameter int BAND    = 20,
    parameter int QUAL_N  = 40,
    parameter int FAIL_N  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_vld,
    input  logic signed [W-1:0]          smp_in,
    output logic [$clog2(MAX_LEN)-1:0]   smp_idx,
    output logic [1:0]                   smp_quad,
    output logic                         mains_ok,
    output logic                         mains_fail
);

    localparam int IDX_W   = $clog2(MAX_LEN);
    localparam int LEN_W   = IDX_W + 1;
    localparam int CNT_MAX = (HOLD_N > QUAL_N) ? ((HOLD_N > FAIL_N) ? HOLD_N : FAIL_N)
                                               : ((QUAL_N > FAIL_N) ? QUAL_N : FAIL_N);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int GAP_W   = $clog2(GAP_MAX + 2);

    localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_N - 1);
    localparam logic [CNT_W-1:0] QUAL_END = CNT_W'(QUAL_N - 1);
    localparam logic [CNT_W-1:0] FAIL_END = CNT_W'(FAIL_N - 1);
    localparam logic [GAP_W-1:0] GAP_LIM  = GAP_W'(GAP_MAX);
    localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(GAP_MAX + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_LEN - 1);
    localparam logic [W:0]       HI_MAG   = (W+1)'(HI_LVL);

    mq_state_e st_q, st_d;

    logic [CNT_W-1:0]    cnt_q;
    logic [GAP_W-1:0]    gap_q, gap_n;
    logic [IDX_W-1:0]    idx_q, nidx, wr_idx;
    logic [LEN_W-1:0]    len_q, idx_p1;
    logic [1:0]          cyc_q;
    logic                ok_q, fail_q;
    logic                zc, in_band, hi_ok, wrap, wr_en, wr_add, fail_evt;
    logic signed [W:0]   smp_x;
    logic [W:0]          mag;
    logic signed [W-1:0] ref_val;

    // ---------------- sub-blocks ----------------
    mq_zc_det #(.W(W), .ZC_RISE(ZC_RISE)) u_zc (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in), .zc(zc)
    );

    mq_ref_mem #(.W(W), .DEPTH(MAX_LEN), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_add(wr_add), .wr_idx(wr_idx),
        .wr_val(smp_in), .rd_idx(nidx), .rd_ref(ref_val)
    );

    mq_band #(.W(W), .BAND(BAND), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_band (
        .smp_in(smp_in), .ref_val(ref_val), .idx(idx_q), .len(len_q),
        .in_band(in_band), .quad(smp_quad)
    );

    // ---------------- sample-level decode ----------------
    assign smp_x  = {smp_in[W-1], smp_in};
    assign mag    = smp_x[W] ? -smp_x : smp_x;
    assign gap_n  = (mag >= HI_MAG) ? '0 : ((gap_q == GAP_SAT) ? gap_q : gap_q + 1'b1);
    assign hi_ok  = gap_n <= GAP_LIM;

    assign idx_p1 = LEN_W'(idx_q) + 1'b1;
    assign wrap   = idx_p1 >= len_q;
    assign nidx   = (zc || wrap) ? '0 : idx_p1[IDX_W-1:0];

    assign wr_idx = zc ? '0 : idx_p1[IDX_W-1:0];
    assign wr_en  = smp_vld && (((st_q == MQ_SEEK) && zc) ||
                    ((st_q == MQ_LEARN) && (zc ? (cyc_q != 2'd3) : (idx_q != IDX_LAST))));
    assign wr_add = (st_q == MQ_LEARN) && (zc || (cyc_q != 2'd0));

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (smp_vld) begin
            unique case (st_q)
                MQ_HOLD:    if (hi_ok && cnt_q == HOLD_END) st_d = MQ_SEEK;
                MQ_SEEK:    if (zc) st_d = MQ_LEARN;
                MQ_LEARN: begin
                    if (zc && cyc_q == 2'd3)            st_d = MQ_QUAL;
                    else if (!zc && idx_q == IDX_LAST)  st_d = MQ_HOLD;
                end
                MQ_QUAL:    if (in_band && cnt_q == QUAL_END) st_d = MQ_PRESENT;
                MQ_PRESENT: if (!in_band && cnt_q == FAIL_END) st_d = MQ_HOLD;
                default:    st_d = MQ_HOLD;
            endcase
        end
    end

    assign fail_evt = (st_q == MQ_PRESENT) && (st_d == MQ_HOLD);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MQ_HOLD;
        else        st_q <= st_d;
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            ok_q <= (st_d == MQ_PRESENT);
            if (fail_evt)                  fail_q <= 1'b1;
            else if (st_d == MQ_PRESENT)   fail_q <= 1'b0;
        end
    end

    assign mains_ok   = ok_q;
    assign mains_fail = fail_q;
    assign smp_idx    = idx_q;

    // ---------------- counters and index ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            gap_q <= GAP_SAT;
            idx_q <= '0;
            len_q <= LEN_W'(MAX_LEN);
            cyc_q <= '0;
        end else if (smp_vld) begin
            gap_q <= gap_n;
            if (st_d != st_q) begin
                cnt_q <= '0;
            end else begin
                case (st_q)
                    MQ_HOLD:    cnt_q <= hi_ok   ? cnt_q + 1'b1 : '0;
                    MQ_QUAL:    cnt_q <= in_band ? cnt_q + 1'b1 : '0;
                    MQ_PRESENT: cnt_q <= in_band ? '0 : cnt_q + 1'b1;
                    default:    cnt_q <= '0;
                endcase
            end
            case (st_q)
                MQ_SEEK: begin
                    if (zc) begin
                        idx_q <= '0;
                        cyc_q <= '0;
                    end
                end
                MQ_LEARN: begin
                    if (zc) begin
                        len_q <= idx_p1;
                        idx_q <= '0;
                        cyc_q <= cyc_q + 1'b1;
                    end else begin
                        idx_q <= (idx_q == IDX_LAST) ? '0 : idx_p1[IDX_W-1:0];
                    end
                end
                MQ_QUAL, MQ_PRESENT: idx_q <= nidx;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mq_chk.sv
module mq_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic [IDX_W-1:0] smp_idx,
    input logic             mains_ok,
    input logic             mains_fail
);

    AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mains_ok && mains_fail)); // R10

    AST_IDX_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_vld) |-> $stable(smp_idx)); // R8

    AST_OK_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mains_ok) |-> $past(smp_vld)); // R5

    AST_FAIL_FROM_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mains_fail) |-> ($past(mains_ok) && !mains_ok)); // R6

    AST_FAIL_CLEAR_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mains_fail) |-> $rose(mains_ok)); // R7

    AST_FAIL_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mains_fail) |-> $past(smp_vld)); // R10

endmodule

bind mains_qual mq_chk #(.IDX_W(IDX_W)) u_mq_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_idx(smp_idx),
    .mains_ok(mains_ok), .mains_fail(mains_fail)
);

// File: tb/mains_qual_tb.sv
`timescale 1ns/1ps
module mains_qual_tb;

    localparam int W       = 12;
    localparam int MAX_LEN = 32;
    localparam int HOLD_N  = 25;
    localparam int GAP_MAX = 12;
    localparam int HI_LVL  = 300;
    localparam int ZC_RISE = 40;
    localparam int BAND    = 20;
    localparam int QUAL_N  = 40;
    localparam int FAIL_N  = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_vld = 1'b0;
    logic signed [W-1:0] smp_in = '0;
    logic [4:0]          smp_idx;
    logic [1:0]          smp_quad;
    logic                mains_ok, mains_fail;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    mains_qual #(
        .W(W), .MAX_LEN(MAX_LEN), .HOLD_N(HOLD_N), .GAP_MAX(GAP_MAX), .HI_LVL(HI_LVL),
        .ZC_RISE(ZC_RISE), .BAND(BAND), .QUAL_N(QUAL_N), .FAIL_N(FAIL_N)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
        .smp_idx(smp_idx), .smp_quad(smp_quad), .mains_ok(mains_ok), .mains_fail(mains_fail)
    );

    function automatic int sv(int k, int p, real amp);
        real a;
        a = amp * $sin(6.283185307179586 * (real'(k) + 0.5) / real'(p));
        return int'(a);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input int v);
        @(negedge clk);
        smp_in  = W'(v);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        smp_vld = 1'b0;
        smp_in  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        // Scenario A: period 20, qualify, fail, requalify with a glitch
        do_reset();
        chk("R1 ok after reset", int'(mains_ok), 0);
        chk("R1 fail after reset", int'(mains_fail), 0);
        chk("R1 idx after reset", int'(smp_idx), 0);
        for (int k = 0; k <= 330; k++) begin
            int v;
            int eok, efail;
            string tag;
            v = sv(k, 20, 1000.0);
            if ((k >= 163 && k <= 166) || (k >= 168 && k <= 172) || k == 285) v += 100;
            put(v);
            eok   = ((k >= 160 && k < 172) || k >= 325) ? 1 : 0;
            efail = (k >= 172 && k < 325) ? 1 : 0;
            if (k < 40)                   tag = "R2 ok before crossing";
            else if (k <= 120)            tag = "R4 ok during learning";
            else if (k <= 162)            tag = "R5 ok at qualification";
            else if (k <= 172)            tag = "R6 ok during failure run";
            else if (k >= 285 && k <= 325) tag = "R5 ok after qual restart";
            else                          tag = "R7 ok during requalification";
            chk(tag, int'(mains_ok), eok);
            chk((k <= 172) ? "R6 fail flag" : "R7 fail flag held", int'(mains_fail), efail);
            chk("R10 ok and fail exclusive", int'(mains_ok && mains_fail), 0);
            if ((k >= 40 && k <= 172) || k >= 200)
                chk("R8 index", int'(smp_idx), k % 20);
            if ((k >= 121 && k <= 172) || k >= 281)
                chk("R9 quadrant", int'(smp_quad), (k % 20) * 4 / 20);
        end

        // Scenario B: period 16, index wrap at a different captured length
        do_reset();
        for (int k = 0; k <= 150; k++) begin
            put(sv(k, 16, 1000.0));
            chk("R8 ok with period 16", int'(mains_ok), (k >= 136) ? 1 : 0);
            if (k >= 32) chk("R8 index wrap 16", int'(smp_idx), k % 16);
            if (k >= 97) chk("R9 quadrant 16", int'(smp_quad), (k % 16) * 4 / 16);
        end

        // Scenario C: noisy crossing with too small a rise during search
        do_reset();
        for (int k = 0; k <= 30; k++) put(sv(k, 20, 1000.0));
        put(-5);
        put(5);
        for (int k = 31; k <= 165; k++) begin
            put(sv(k, 20, 1000.0));
            if (k == 31) chk("R3 weak crossing ignored idx", int'(smp_idx), 0);
            chk("R3 ok timing after weak crossing", int'(mains_ok), (k >= 160) ? 1 : 0);
        end

        // Scenario D: low-amplitude lead-in does not count as high voltage
        do_reset();
        for (int k = 0; k <= 210; k++) begin
            put(sv(k, 20, (k < 40) ? 200.0 : 1000.0));
            if (k >= 150) chk("R2 persistence after low lead-in", int'(mains_ok), (k >= 200) ? 1 : 0);
        end

        finish_run();
    end

endmodule